// File: doc/BRIEF.md
# Nonvolatile Save/Restore Controller

This block sequences data movement between a volatile SRAM array and the nonvolatile shadow cells behind it. A save copies the array into the shadow; a restore first wipes the array and then loads it from the shadow, leaving the shadow untouched. Four causes can start a transfer: a software pulse, an external agent holding the shared open-drain busy line low, the supply falling below its switch threshold, and the supply coming up. The controller also drives that busy line low itself for the length of every save.

A dirty flag records whether any write has completed since the last save. A software save always runs. A save caused by the busy line or by a supply drop runs only when the flag is set. While a transfer runs, the access enables stay low. After a save, or after a busy-line save that is skipped, the controller stays locked until the busy line reads high again. When the busy line goes low, reads continue for a short grace window. A write attempt or any bus activity inside that window starts the save at once.

All durations are counted in system clock cycles and set by parameters.

Top module: `nv_shadow_ctrl`

## Requirements
- R1: After reset every output is low and the block waits. When `vcc_good_i` goes high, `arr_clr_o` is high for CLR_CYC cycles, then `arr_copy_o` is high for CPY_CYC cycles, and then `acc_en_o` goes high.
- R2: While any of `arr_clr_o`, `arr_copy_o` or `arr_save_o` is high, both `acc_en_o` and `wr_en_o` are low.
- R3: In the idle state with `cap_good_i` high, a one-cycle `sw_save_i` starts a save on the next edge, whether or not the array is dirty. `arr_save_o` is then high for SAVE_CYC cycles and `busy_pd_o` stays high throughout.
- R4: When a save ends with the supply still good, `acc_en_o` stays low for as long as `busy_n_i` reads low. It rises one cycle after the line is sampled high.
- R5: In idle, if `busy_n_i` is low on MIN_PULSE consecutive edges while the array is dirty and `cap_good_i` is high, a grace window of GRACE_CYC cycles follows. During the window `acc_en_o` is high and `wr_en_o` is low. The save starts when the window ends.
- R6: A `bus_evt_i` or `wr_try_i` pulse during the grace window starts the save on the next edge.
- R7: `wr_en_o` is low whenever `busy_n_i` is low, even while reads are still enabled. It is high in idle when the line is high.
- R8: A qualified busy-line request is skipped when the array is clean or `cap_good_i` is low. No save runs, and `acc_en_o` goes low until the line reads high.
- R9: `sw_save_i` with `cap_good_i` low is ignored: no save runs and `acc_en_o` stays high.
- R10: A `wr_done_i` pulse sets the dirty flag. A completed save clears it. A restore leaves it unchanged.
- R11: If the supply drops in idle while the array is dirty, `busy_pd_o` rises for one probe cycle. If `busy_n_i` reads low in that cycle, a full save follows. If it reads high, the attempt is abandoned with no save. Either way the block ends in the powered-down wait state.
- R12: If the supply drops while the array is clean, no save runs and `busy_pd_o` stays low. The next supply rise runs a full restore.
- R13: In idle, a one-cycle `sw_restore_i` runs the clear phase for CLR_CYC cycles and then the copy phase for CPY_CYC cycles, with `busy_pd_o` low throughout, and then returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vcc_good_i | input | 1 | Main supply above switch threshold |
| cap_good_i | input | 1 | Hold-up capacitor above switch threshold |
| sw_save_i | input | 1 | Software save request pulse |
| sw_restore_i | input | 1 | Software restore request pulse |
| busy_n_i | input | 1 | Sensed level of the shared busy line (low = busy) |
| busy_pd_o | output | 1 | Enable of the busy line pull-down |
| wr_done_i | input | 1 | Strobe: an SRAM write completed |
| bus_evt_i | input | 1 | Strobe: address or control transition on the SRAM port |
| wr_try_i | input | 1 | Strobe: an SRAM write is being attempted |
| acc_en_o | output | 1 | SRAM read access permitted |
| wr_en_o | output | 1 | SRAM write access permitted |
| arr_clr_o | output | 1 | Array clear phase active |
| arr_copy_o | output | 1 | Shadow-to-array copy phase active |
| arr_save_o | output | 1 | Array-to-shadow save phase active |

## Verification
The assertions assume that `wr_done_i` pulses only after a write that `wr_en_o` allowed, so the dirty flag never changes during a save or a probe. They also assume that the request strobes are single-cycle and arrive only while the block is idle. The bench keeps to these assumptions: it raises `wr_done_i` only in idle with the line high, and it drives every strobe for one cycle. It models the busy line as a wired-AND of the pull-down and an external driver, and it has a separate override that holds the line high to exercise the abandon path.

// File: rtl/nvx_pkg.sv
`timescale 1ns/1ps
package nvx_pkg;
  typedef enum logic [2:0] {
    S_OFF,
    S_RCLR,
    S_RCPY,
    S_IDLE,
    S_GRACE,
    S_PROBE,
    S_SAVE,
    S_LOCK
  } nvx_state_e;
endpackage

// File: rtl/nvx_timer.sv
`timescale 1ns/1ps
module nvx_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  AST_TMR_HOLD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o && !load_i |=> zero_o); // R3
endmodule

// File: rtl/nvx_pulse_qual.sv
`timescale 1ns/1ps
module nvx_pulse_qual #(
  parameter int MIN_PULSE = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic line_n_i,
  output logic hit_o
);
  localparam int CW = (MIN_PULSE > 1) ? $clog2(MIN_PULSE) : 1;
  localparam logic [CW-1:0] LAST = CW'(MIN_PULSE - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!en_i || line_n_i)   cnt_q <= '0;
    else if (cnt_q < LAST)        cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = en_i && !line_n_i && (cnt_q == LAST);

  generate
    if (MIN_PULSE > 1) begin : g_chk
      AST_QUAL_PRIOR_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_o |-> $past(!line_n_i)); // R5
    end
  endgenerate
endmodule

// File: rtl/nvx_dirty.sv
`timescale 1ns/1ps
module nvx_dirty (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic dirty_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dirty_o <= 1'b0;
    else if (clr_i)  dirty_o <= 1'b0;
    else if (set_i)  dirty_o <= 1'b1;
  end

  AST_DIRTY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i && !clr_i |=> dirty_o); // R10
endmodule

// File: rtl/nv_shadow_ctrl.sv
`timescale 1ns/1ps
module nv_shadow_ctrl #(
  parameter int SAVE_CYC  = 20,
  parameter int CLR_CYC   = 8,
  parameter int CPY_CYC   = 12,
  parameter int GRACE_CYC = 6,
  parameter int MIN_PULSE = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vcc_good_i,
  input  logic cap_good_i,
  input  logic sw_save_i,
  input  logic sw_restore_i,
  input  logic busy_n_i,
  output logic busy_pd_o,
  input  logic wr_done_i,
  input  logic bus_evt_i,
  input  logic wr_try_i,
  output logic acc_en_o,
  output logic wr_en_o,
  output logic arr_clr_o,
  output logic arr_copy_o,
  output logic arr_save_o
);
  import nvx_pkg::*;

  localparam int M0   = (SAVE_CYC > CLR_CYC) ? SAVE_CYC : CLR_CYC;
  localparam int M1   = (CPY_CYC > GRACE_CYC) ? CPY_CYC : GRACE_CYC;
  localparam int MAXC = (M0 > M1) ? M0 : M1;
  localparam int CW   = $clog2(MAXC + 1);

  nvx_state_e    st_q, st_d;
  logic          tmr_zero, tmr_ld, qual_hit, dirty_q, save_fin;
  logic [CW-1:0] tmr_val;

  nvx_timer #(.CW(CW)) u_timer (
    .clk_i, .rst_ni, .load_i(tmr_ld), .load_val_i(tmr_val), .zero_o(tmr_zero)
  );

  nvx_pulse_qual #(.MIN_PULSE(MIN_PULSE)) u_qual (
    .clk_i, .rst_ni, .en_i(st_q == S_IDLE), .line_n_i(busy_n_i), .hit_o(qual_hit)
  );

  nvx_dirty u_dirty (
    .clk_i, .rst_ni, .set_i(wr_done_i), .clr_i(save_fin), .dirty_o(dirty_q)
  );

  always_comb begin
    st_d     = st_q;
    save_fin = 1'b0;
    unique case (st_q)
      S_OFF:   if (vcc_good_i) st_d = S_RCLR;
      S_RCLR:  if (!vcc_good_i) st_d = S_OFF;
               else if (tmr_zero) st_d = S_RCPY;
      S_RCPY:  if (!vcc_good_i) st_d = S_OFF;
               else if (tmr_zero) st_d = S_IDLE;
      S_IDLE: begin
        if (!vcc_good_i)                  st_d = dirty_q ? S_PROBE : S_OFF;
        else if (qual_hit)                st_d = (dirty_q && cap_good_i) ? S_GRACE : S_LOCK;
        else if (sw_save_i && cap_good_i) st_d = S_SAVE;
        else if (sw_restore_i)            st_d = S_RCLR;
      end
      S_GRACE: if (!vcc_good_i) st_d = S_PROBE;
               else if (tmr_zero || bus_evt_i || wr_try_i) st_d = S_SAVE;
      // one probe cycle: line must really read low
      S_PROBE: st_d = busy_n_i ? S_OFF : S_SAVE;
      S_SAVE: begin
        if (tmr_zero) begin
          save_fin = 1'b1;
          st_d     = vcc_good_i ? S_LOCK : S_OFF;
        end
      end
      S_LOCK:  if (!vcc_good_i) st_d = dirty_q ? S_PROBE : S_OFF;
               else if (busy_n_i) st_d = S_IDLE;
      default: st_d = S_OFF;
    endcase
  end

  always_comb begin
    tmr_ld  = (st_d != st_q);
    tmr_val = '0;
    unique case (st_d)
      S_RCLR:  tmr_val = CW'(CLR_CYC - 1);
      S_RCPY:  tmr_val = CW'(CPY_CYC - 1);
      S_GRACE: tmr_val = CW'(GRACE_CYC - 1);
      S_SAVE:  tmr_val = CW'(SAVE_CYC - 1);
      default: tmr_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= S_OFF;
    else         st_q <= st_d;
  end

  assign acc_en_o   = (st_q == S_IDLE) || (st_q == S_GRACE);
  assign wr_en_o    = (st_q == S_IDLE) && busy_n_i;
  assign busy_pd_o  = (st_q == S_PROBE) || (st_q == S_SAVE);
  assign arr_clr_o  = (st_q == S_RCLR);
  assign arr_copy_o = (st_q == S_RCPY);
  assign arr_save_o = (st_q == S_SAVE);

  AST_XFER_BLOCKS_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_save_o || arr_clr_o || arr_copy_o) |-> (!acc_en_o && !wr_en_o)); // R2
  AST_SAVE_HOLDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_save_o |-> busy_pd_o); // R3
  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_LOCK && !busy_n_i && vcc_good_i) |=> !acc_en_o); // R4
  AST_SW_INHIBIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_IDLE && sw_save_i && !cap_good_i) |=> !arr_save_o); // R9
  AST_SAVE_NEEDS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(arr_save_o) |-> ($past(dirty_q) || $past(sw_save_i))); // R10
  AST_DIRTY_CLR_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(arr_save_o) |-> !dirty_q); // R10
  AST_PROBE_RESOLVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_PROBE) |=> (arr_save_o || (!busy_pd_o && !acc_en_o))); // R11
  AST_CLR_BEFORE_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(arr_copy_o) |-> $past(arr_clr_o)); // R13
endmodule

// File: tb/nv_shadow_ctrl_test.sv
`timescale 1ns/1ps
module nv_shadow_ctrl_test;
  localparam int SAVE_CYC  = 20;
  localparam int CLR_CYC   = 8;
  localparam int CPY_CYC   = 12;
  localparam int GRACE_CYC = 6;
  localparam int MIN_PULSE = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic vcc_good = 1'b0, cap_good = 1'b1;
  logic sw_save = 1'b0, sw_restore = 1'b0;
  logic wr_done = 1'b0, bus_evt = 1'b0, wr_try = 1'b0;
  logic ext_low = 1'b0, force_high = 1'b0;
  logic busy_n, busy_pd, acc_en, wr_en, arr_clr, arr_copy, arr_save;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  // wired-AND busy line with optional strong pull-up
  assign busy_n = force_high | ~(busy_pd | ext_low);

  nv_shadow_ctrl #(
    .SAVE_CYC(SAVE_CYC), .CLR_CYC(CLR_CYC), .CPY_CYC(CPY_CYC),
    .GRACE_CYC(GRACE_CYC), .MIN_PULSE(MIN_PULSE)
  ) uut (
    .clk_i(clk), .rst_ni(rst_ni), .vcc_good_i(vcc_good), .cap_good_i(cap_good),
    .sw_save_i(sw_save), .sw_restore_i(sw_restore), .busy_n_i(busy_n),
    .busy_pd_o(busy_pd), .wr_done_i(wr_done), .bus_evt_i(bus_evt), .wr_try_i(wr_try),
    .acc_en_o(acc_en), .wr_en_o(wr_en), .arr_clr_o(arr_clr), .arr_copy_o(arr_copy),
    .arr_save_o(arr_save)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  function automatic logic sig(input int which);
    case (which)
      0:       return arr_clr;
      1:       return arr_copy;
      default: return arr_save;
    endcase
  endfunction

  task automatic run_phase(input int which, input string req, input int exp_len, input logic exp_pd);
    int n = 0;
    int bad_acc = 0;
    int bad_pd = 0;
    while (sig(which) && n < 1000) begin
      n++;
      if (acc_en || wr_en) bad_acc++;
      if (busy_pd != exp_pd) bad_pd++;
      nxt();
    end
    chk({req, " phase length"}, n, exp_len);
    chk("R2 access blocked in phase", bad_acc, 0);
    chk({req, " busy pull-down level"}, bad_pd, 0);
  endtask

  task automatic pulse_write();
    wr_done = 1'b1; nxt(); wr_done = 1'b0;
  endtask

  task automatic do_restore(input string req, input bit by_sw);
    if (by_sw) begin
      sw_restore = 1'b1; nxt(); sw_restore = 1'b0;
    end else begin
      vcc_good = 1'b1; nxt();
    end
    chk({req, " clear starts"}, arr_clr, 1);
    run_phase(0, req, CLR_CYC, 1'b0);
    chk({req, " copy follows clear"}, arr_copy, 1);
    run_phase(1, req, CPY_CYC, 1'b0);
    chk({req, " access after restore"}, acc_en, 1);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) nxt();
    rst_ni = 1'b1;
    nxt();
    chk("R1 reset acc_en", acc_en, 0);
    chk("R1 reset busy_pd", busy_pd, 0);
    chk("R1 reset strobes", {arr_clr, arr_copy, arr_save}, 0);
    repeat (3) nxt();
    chk("R1 waits for supply", acc_en | arr_clr, 0);
  endtask

  task automatic t_sw_save();
    chk("R7 write enabled in idle", wr_en, 1);
    sw_save = 1'b1; nxt(); sw_save = 1'b0;
    ext_low = 1'b1;
    chk("R3 save starts clean", arr_save, 1);
    run_phase(2, "R3", SAVE_CYC, 1'b1);
    chk("R4 locked after save", acc_en, 0);
    repeat (3) nxt();
    chk("R4 lock held while line low", acc_en, 0);
    ext_low = 1'b0;
    nxt();
    chk("R4 release on line high", acc_en, 1);
  endtask

  task automatic t_busy_skip();
    int saves = 0;
    ext_low = 1'b1;
    nxt();
    chk("R7 write blocked while line low", wr_en, 0);
    chk("R7 read still enabled", acc_en, 1);
    repeat (MIN_PULSE - 2) nxt();
    chk("R8 not yet qualified", acc_en, 1);
    nxt();
    chk("R8 clean request locks", acc_en, 0);
    for (int i = 0; i < 5; i++) begin
      saves += arr_save;
      nxt();
    end
    chk("R10 clean array skips save", saves, 0);
    ext_low = 1'b0;
    nxt();
    chk("R8 unlock on line high", acc_en, 1);
  endtask

  task automatic t_busy_grace();
    int n = 0;
    int bad = 0;
    pulse_write();
    ext_low = 1'b1;
    repeat (MIN_PULSE) nxt();
    chk("R5 grace reads on", acc_en, 1);
    chk("R5 grace writes off", wr_en, 0);
    while (!arr_save && n < 100) begin
      n++;
      if (!acc_en) bad++;
      nxt();
    end
    chk("R5 grace length", n, GRACE_CYC);
    chk("R5 reads kept in grace", bad, 0);
    run_phase(2, "R5", SAVE_CYC, 1'b1);
    ext_low = 1'b0;
    nxt();
    chk("R5 idle after release", acc_en, 1);
  endtask

  task automatic t_grace_evt(input bit use_wr);
    pulse_write();
    ext_low = 1'b1;
    repeat (MIN_PULSE + 1) nxt();
    chk("R6 still in grace", acc_en & ~arr_save, 1);
    if (use_wr) wr_try = 1'b1; else bus_evt = 1'b1;
    nxt();
    wr_try = 1'b0; bus_evt = 1'b0;
    chk(use_wr ? "R6 write attempt starts save" : "R6 bus event starts save", arr_save, 1);
    run_phase(2, "R6", SAVE_CYC, 1'b1);
    ext_low = 1'b0;
    nxt();
    chk("R6 idle after release", acc_en, 1);
  endtask

  task automatic t_cap_inhibit();
    int saves = 0;
    cap_good = 1'b0;
    sw_save = 1'b1; nxt(); sw_save = 1'b0;
    chk("R9 sw save ignored", arr_save, 0);
    chk("R9 access kept", acc_en, 1);
    pulse_write();
    ext_low = 1'b1;
    repeat (MIN_PULSE) nxt();
    chk("R8 low cap busy request locks", acc_en, 0);
    for (int i = 0; i < 4; i++) begin
      saves += arr_save;
      nxt();
    end
    chk("R8 low cap no save", saves, 0);
    ext_low = 1'b0;
    nxt();
    chk("R8 unlock", acc_en, 1);
    cap_good = 1'b1;
  endtask

  task automatic t_pd_save();
    vcc_good = 1'b0;
    nxt();
    chk("R11 probe pulls line", busy_pd, 1);
    chk("R11 no save during probe", arr_save, 0);
    nxt();
    chk("R11 save after low probe", arr_save, 1);
    run_phase(2, "R11", SAVE_CYC, 1'b1);
    chk("R11 off after save", acc_en | busy_pd, 0);
    repeat (3) nxt();
    chk("R11 stays off", acc_en, 0);
    do_restore("R1", 1'b0);
  endtask

  task automatic t_pd_clean();
    int act = 0;
    vcc_good = 1'b0;
    nxt();
    chk("R12 no pull-down when clean", busy_pd, 0);
    for (int i = 0; i < 5; i++) begin
      act += busy_pd + arr_save + acc_en;
      nxt();
    end
    chk("R12 no save when clean", act, 0);
    do_restore("R12", 1'b0);
  endtask

  task automatic t_pd_abandon();
    int saves = 0;
    pulse_write();
    force_high = 1'b1;
    vcc_good = 1'b0;
    nxt();
    chk("R11 probe pulls line", busy_pd, 1);
    nxt();
    chk("R11 abandon releases line", busy_pd, 0);
    chk("R11 abandon locks out", acc_en, 0);
    for (int i = 0; i < 10; i++) begin
      saves += arr_save;
      nxt();
    end
    chk("R11 abandon no save", saves, 0);
    force_high = 1'b0;
    do_restore("R11", 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    nxt();
    t_reset();
    do_restore("R1", 1'b0);
    t_sw_save();
    t_busy_skip();
    t_busy_grace();
    t_grace_evt(1'b0);
    t_grace_evt(1'b1);
    t_cap_inhibit();
    do_restore("R13", 1'b1);
    t_pd_save();
    t_pd_clean();
    t_pd_abandon();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule